// File: doc/BRIEF.md
# Maskable Pending Interrupt Vector Controller

This block gathers a set of peripheral event pulses into one interrupt request line for a processor core. Every event is recorded in a pending register whatever the mask says. A mask register decides which pending events may raise the request line. Source 0 is an error source that no mask bit can block.

When the core acknowledges, the block picks the highest-numbered pending source that is allowed to request and returns its index as a 5-bit vector. It then clears that pending bit. A mask write that lands in the same cycle as the acknowledge is honoured at once. The selection then falls back to the next eligible source. If no other source is eligible, the block returns the all-zero vector. Software reaches both registers through a small register port: address 0 selects the mask and address 1 selects the pending register.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the mask register reads all zeros, the pending register reads all zeros, and `irqOut`, `ackValid` and `ackVec` are 0.
- R2: A pulse on `srcEvt[i]` sets pending bit i at the next clock edge, whether or not mask bit i is set. The pending register reads back at address 1.
- R3: A write to address 0 loads the mask register, and the register reads back at address 0 at any time. Mask bit 0 always reads 0 and has no function. A mask bit of 1 enables its source and a 0 masks it.
- R4: `irqOut` is a register. It is 1 one cycle after the state in which some pending bit i in 1..15 has mask bit i set, or pending bit 0 is set; otherwise it is 0. Source 0 is the unmaskable error source.
- R5: When `ackReq` is 1, `ackValid` is 1 in the next cycle. `ackVec` then holds the highest index among pending bits that are eligible: mask bit set for indices 1..15, and bit 0 always eligible. If no pending bit is eligible, `ackVec` is 0. `ackVec` holds its value until the next acknowledge, and `ackValid` is 0 in cycles that follow no acknowledge.
- R6: The pending bit of the source returned by an acknowledge is cleared at the same edge that loads `ackVec`.
- R7: A mask write in the same cycle as `ackReq` decides eligibility with the newly written mask. The vector falls back to the next eligible pending source, or to 0 if there is none.
- R8: Writing 1 to a bit at address 1 clears that pending bit, and writing 0 to a bit leaves it unchanged. An event on the same bit in the same cycle leaves the bit set.
- R9: Clearing the mask bit of a requesting source drops `irqOut` while the pending bit stays set. Setting the mask bit again raises `irqOut` once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvt | input | 16 | Single-cycle event pulses; bit 0 is the error source |
| regAddr | input | 1 | Register select: 0 mask, 1 pending |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data of the selected register |
| ackReq | input | 1 | Acknowledge request from the core |
| irqOut | output | 1 | Registered interrupt request |
| ackValid | output | 1 | Vector valid, one cycle after `ackReq` |
| ackVec | output | 5 | Acknowledged source index, 0 for the error vector |

## Verification
The hardest situation to reach from the ports is the race between a mask write and an acknowledge in the same cycle. Covering it fully needs both outcomes: a fallback to a lower pending source, and a fallback to the zero vector while a masked source is still pending. Directed sequences first build a known pending and mask state. They then issue the write and `ackReq` together. Long random runs also mix writes and acknowledges so that these collisions recur, with a bench model predicting every cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned DefNumSrc = 16;
  localparam int unsigned DefVecW   = 5;

  typedef struct packed {
    logic maskWr;   // load mask register this cycle
    logic pendWr;   // write-one-to-clear on pending register
    logic ackTake;  // take an acknowledge this cycle
  } ctlStrb_t;
endpackage

// File: rtl/irq_vec_ctrl_prio.sv
module irq_vec_ctrl_prio #(
  parameter int unsigned NumSrc = 16,
  parameter int unsigned VecW   = 5
) (
  input  logic [NumSrc-1:0] cand,
  output logic [VecW-1:0]   winIdx,
  output logic [NumSrc-1:0] winOh
);
  // ascending scan: the last hit is the highest index
  always_comb begin
    winIdx = '0;
    winOh  = '0;
    for (int i = 0; i < NumSrc; i++) begin
      if (cand[i]) begin
        winIdx   = VecW'(i);
        winOh    = '0;
        winOh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_ctl.sv
module irq_vec_ctrl_ctl
  import irq_vec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regWr,
  input  logic     regAddr,
  input  logic     ackReq,
  output ctlStrb_t strb,
  output logic     ackValid
);
  always_comb begin
    strb.maskWr  = regWr && !regAddr;
    strb.pendWr  = regWr && regAddr;
    strb.ackTake = ackReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackValid <= 1'b0;
    else       ackValid <= ackReq;
  end
endmodule

// File: rtl/irq_vec_ctrl_dp.sv
module irq_vec_ctrl_dp
  import irq_vec_pkg::*;
#(
  parameter int unsigned NumSrc = 16,
  parameter int unsigned VecW   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [NumSrc-1:0] srcEvt,
  input  logic              regAddr,
  input  logic [NumSrc-1:0] regWdata,
  output logic [NumSrc-1:0] regRdata,
  output logic              irqOut,
  output logic [VecW-1:0]   ackVec,
  output logic [NumSrc-1:0] maskQ,
  output logic [NumSrc-1:0] pendQ
);
  localparam logic [NumSrc-1:0] ErrBit = NumSrc'(1);

  logic [NumSrc-1:0] effMask;
  logic [NumSrc-1:0] cand;
  logic [NumSrc-1:0] winOh;
  logic [VecW-1:0]   winIdx;
  logic [NumSrc-1:0] pendClr;
  logic [NumSrc-1:0] pendD;
  logic              irqD;

  // a mask write racing an acknowledge takes effect for the selection
  assign effMask = (strb.maskWr ? regWdata : maskQ) | ErrBit;
  assign cand    = pendQ & effMask;

  irq_vec_ctrl_prio #(.NumSrc(NumSrc), .VecW(VecW)) uPrio (
    .cand  (cand),
    .winIdx(winIdx),
    .winOh (winOh)
  );

  assign pendClr = (strb.pendWr ? regWdata : '0) | (strb.ackTake ? winOh : '0);
  assign pendD   = (pendQ & ~pendClr) | srcEvt;
  assign irqD    = |(pendQ & (maskQ | ErrBit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      pendQ  <= '0;
      irqOut <= 1'b0;
      ackVec <= '0;
    end else begin
      if (strb.maskWr) maskQ <= regWdata & ~ErrBit;
      pendQ  <= pendD;
      irqOut <= irqD;
      if (strb.ackTake) ackVec <= winIdx;
    end
  end

  assign regRdata = regAddr ? pendQ : maskQ;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NumSrc = DefNumSrc,
  parameter int unsigned VecW   = DefVecW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcEvt,
  input  logic              regAddr,
  input  logic              regWr,
  input  logic [NumSrc-1:0] regWdata,
  output logic [NumSrc-1:0] regRdata,
  input  logic              ackReq,
  output logic              irqOut,
  output logic              ackValid,
  output logic [VecW-1:0]   ackVec
);
  ctlStrb_t          strb;
  logic [NumSrc-1:0] maskQ;
  logic [NumSrc-1:0] pendQ;

  irq_vec_ctrl_ctl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .ackReq  (ackReq),
    .strb    (strb),
    .ackValid(ackValid)
  );

  irq_vec_ctrl_dp #(.NumSrc(NumSrc), .VecW(VecW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcEvt  (srcEvt),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut  (irqOut),
    .ackVec  (ackVec),
    .maskQ   (maskQ),
    .pendQ   (pendQ)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int unsigned NumSrc = 16,
  parameter int unsigned VecW   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [NumSrc-1:0] srcEvt,
  input logic              regAddr,
  input logic              regWr,
  input logic [NumSrc-1:0] regWdata,
  input logic              ackReq,
  input logic              irqOut,
  input logic              ackValid,
  input logic [VecW-1:0]   ackVec,
  input logic [NumSrc-1:0] maskQ,
  input logic [NumSrc-1:0] pendQ
);
  // R2: an event always lands in pending
  for (genvar i = 0; i < NumSrc; i++) begin : gEvt
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      srcEvt[i] |=> pendQ[i]);
    // R8: write-one-to-clear without a colliding event
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && regAddr && regWdata[i] && !srcEvt[i]) |=> !pendQ[i]);
  end

  // R3: mask bit 0 never holds a 1
  a_r3_bit0_zero: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[0]);

  // R4: the error source cannot be masked
  a_r4_err_requests: assert property (@(posedge clk) disable iff (!rstN)
    pendQ[0] |=> irqOut);

  // R5: valid follows acknowledge, vector held otherwise
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackValid);
  a_r5_vec_held: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> (!ackValid && $stable(ackVec)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NumSrc(NumSrc), .VecW(VecW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .srcEvt  (srcEvt),
  .regAddr (regAddr),
  .regWr   (regWr),
  .regWdata(regWdata),
  .ackReq  (ackReq),
  .irqOut  (irqOut),
  .ackValid(ackValid),
  .ackVec  (ackVec),
  .maskQ   (maskQ),
  .pendQ   (pendQ)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] srcEvt;
  logic        regAddr;
  logic        regWr;
  logic [15:0] regWdata;
  logic [15:0] regRdata;
  logic        ackReq;
  logic        irqOut;
  logic        ackValid;
  logic [4:0]  ackVec;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] mMask, mPend;
  logic        mIrq, mVld;
  logic [4:0]  mVec;

  always #2.5 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rstN(rstN), .srcEvt(srcEvt), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .ackReq(ackReq),
    .irqOut(irqOut), .ackValid(ackValid), .ackVec(ackVec)
  );

  function automatic logic [4:0] pickWinner(input logic [15:0] pend, input logic [15:0] msk);
    logic [15:0] elig;
    elig = pend & {msk[15:1], 1'b1};
    for (int i = 15; i >= 0; i--) if (elig[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update the model at posedge, compare at next negedge
  task automatic cyc(input logic [15:0] evt, input logic wr, input logic addr,
                     input logic [15:0] wd, input logic ack);
    logic [15:0] effM, clr, win1h;
    logic [4:0]  w;
    srcEvt = evt; regWr = wr; regAddr = addr; regWdata = wd; ackReq = ack;
    effM  = (wr && !addr) ? wd : mMask;
    w     = pickWinner(mPend, effM);
    win1h = (mPend[w] && (w == 0 || effM[w])) ? (16'd1 << w) : 16'd0;
    clr   = ((wr && addr) ? wd : 16'd0) | (ack ? win1h : 16'd0);
    @(posedge clk);
    mIrq  = |(mPend & {mMask[15:1], 1'b1});
    mPend = (mPend & ~clr) | evt;
    if (wr && !addr) mMask = wd & 16'hFFFE;
    if (ack) mVec = w;
    mVld = ack;
    @(negedge clk);
    chk("R4 irqOut", 32'(irqOut), 32'(mIrq));
    chk("R5 ackValid", 32'(ackValid), 32'(mVld));
    chk("R5 ackVec", 32'(ackVec), 32'(mVec));
    chk(addr ? "R2 pending read" : "R3 mask read", 32'(regRdata),
        32'(addr ? mPend : mMask));
    srcEvt = '0; regWr = 1'b0; ackReq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; srcEvt = '0; regAddr = 1'b0; regWr = 1'b0; regWdata = '0; ackReq = 1'b0;
    mMask = '0; mPend = '0; mIrq = 1'b0; mVld = 1'b0; mVec = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 mask", 32'(regRdata), 32'h0);
    chk("R1 irqOut", 32'(irqOut), 32'h0);
    chk("R1 ackValid", 32'(ackValid), 32'h0);
    chk("R1 ackVec", 32'(ackVec), 32'h0);
    regAddr = 1'b1; #0.1;
    chk("R1 pending", 32'(regRdata), 32'h0);

    // R2: masked event still pends, no request
    cyc(16'h0200, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R2 pend bit 9", 32'(regRdata), 32'h0200);
    cyc(16'h0, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R2 masked no irq", 32'(irqOut), 32'h0);

    // R9: unmask raises request, mask drops it, pending retained
    cyc(16'h0, 1'b1, 1'b0, 16'h0220, 1'b0);
    cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R9 unmask raises irq", 32'(irqOut), 32'h1);
    cyc(16'h0, 1'b1, 1'b0, 16'h0020, 1'b0);
    cyc(16'h0, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R9 masked drops irq", 32'(irqOut), 32'h0);
    chk("R9 pending kept", 32'(regRdata), 32'h0200);
    cyc(16'h0, 1'b1, 1'b0, 16'h0220, 1'b0);
    cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R9 remask restores irq", 32'(irqOut), 32'h1);

    // R7: mask bit 9 removed in the acknowledge cycle, fall back to 5
    cyc(16'h0020, 1'b0, 1'b1, 16'h0, 1'b0);
    cyc(16'h0, 1'b1, 1'b0, 16'h0020, 1'b1);
    chk("R7 fallback vector", 32'(ackVec), 32'd5);
    regAddr = 1'b1; #0.1;
    chk("R6 ack cleared bit 5", 32'(regRdata), 32'h0200);
    // R7: nothing eligible left, zero vector, bit 9 stays pending
    cyc(16'h0, 1'b1, 1'b0, 16'h0000, 1'b1);
    chk("R7 zero vector", 32'(ackVec), 32'd0);
    chk("R7 ackValid", 32'(ackValid), 32'h1);
    regAddr = 1'b1; #0.1;
    chk("R7 masked stays pending", 32'(regRdata), 32'h0200);

    // R8: write zero no effect, clear colliding with event keeps bit
    cyc(16'h0, 1'b1, 1'b1, 16'h0000, 1'b0);
    chk("R8 write zero", 32'(regRdata), 32'h0200);
    cyc(16'h0200, 1'b1, 1'b1, 16'h0200, 1'b0);
    chk("R8 event wins", 32'(regRdata), 32'h0200);
    cyc(16'h0, 1'b1, 1'b1, 16'h0200, 1'b0);
    chk("R8 write one clears", 32'(regRdata), 32'h0000);

    // R4/R6: error source alone, unmaskable, vector 0 clears it
    cyc(16'h0001, 1'b0, 1'b1, 16'h0, 1'b0);
    cyc(16'h0, 1'b0, 1'b1, 16'h0, 1'b0);
    chk("R4 error irq", 32'(irqOut), 32'h1);
    cyc(16'h0, 1'b0, 1'b1, 16'h0, 1'b1);
    chk("R6 error vector", 32'(ackVec), 32'd0);
    chk("R6 error cleared", 32'(regRdata), 32'h0);

    // R3: bit 0 of mask reads zero
    cyc(16'h0, 1'b1, 1'b0, 16'hFFFF, 1'b0);
    chk("R3 bit0 zero", 32'(regRdata), 32'hFFFE);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ev;
      ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
      if ($urandom % 3 == 0) ev = '0;
      cyc(ev, ($urandom % 4) == 0, 1'($urandom), 16'($urandom), ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule